// File: doc/BRIEF.md
# Edge-Sensing GPIO Interrupt Controller

This block watches a bank of general-purpose inputs and drives one shared, active-low interrupt request toward a host. Each pin has its own two-bit sense code, which selects rising edges, falling edges, both edges, or no detection. Only edges are detected; there is no level-triggered mode. A detected edge sets the pin's bit in a source register. A per-pin mask decides whether that bit can pull the interrupt line low.

Software reaches the block through a byte-wide register port, usually placed behind a serial slave front end. Software clears source bits by writing ones to them. A control bit selects whether a read of a source byte also clears it. Each input is brought into the clock domain by a synchronizer. An edge is found by comparing the synchronized level with its value in the previous cycle.

`NUM_PINS` must be a multiple of 8. The register map scales with it. For the default of 16 pins the map is:
- addresses 0–1: mask.
- addresses 2–3: source.
- addresses 4–7: sense.
- address 8: control.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every mask bit is 1, the source register, sense register and control bit are 0, and `irq_no` is high.
- R2: With sense code 01, a low-to-high change on a pin's input sets its source bit. The bit is set at the third rising clock edge after the change, and an unmasked bit then pulls `irq_no` low.
- R3: Sense code 10 detects only falling edges and code 11 detects both. Code 00 detects none. A pin never latches an edge of a kind its code does not select.
- R4: Pin p's sense code sits at bits [2p+1:2p] of a 32-bit field. Address 4 holds pins 15..12, address 5 pins 11..8, address 6 pins 7..4 and address 7 pins 3..0. The lowest-numbered pin of each byte is in bits [1:0].
- R5: A mask bit of 1 keeps that pin from driving `irq_no`, but its source bit still latches edges. Clearing the mask bit while the source bit is set pulls `irq_no` low on the next cycle.
- R6: Writing a source byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq_no` is low exactly when some source bit is 1 while its mask bit is 0. It goes high in the cycle after the last such bit is cleared or masked.
- R8: With control bit 0 (address 8) at 0, reading a source byte returns its value and then clears it. With control bit 0 at 1, reads leave the source register unchanged.
- R9: If an edge on a pin and a clear of that pin's source bit are sampled on the same clock edge, the bit remains set.
- R10: Read data appears on `reg_rdata_o` one cycle after a read strobe and holds until the next read. Unmapped addresses read as 0 and writes to them change nothing.
- R11: The mask and source registers each span two bytes. The lower address holds pins 15..8 and the next address holds pins 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_PINS | Asynchronous pin levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (4) | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| irq_no | output | 1 | Shared interrupt request, active low |

## Verification
A corrupted source bit shows up in two places. It moves `irq_no` in the very next cycle if the pin is unmasked. It also appears in the next read of that source byte. A wrong mask or sense bit stays hidden until an edge arrives on that pin. Its effect then shows on `irq_no` three clock edges after the input changes, so the bench toggles each sense variant on a separate pin. The bench compares both outputs against its model on every cycle. As a result, a divergence is reported within one cycle of reaching a port, not at the end of a directed sequence.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  function automatic int bytes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/gpio_edge_irq_sync.sv
module gpio_edge_irq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_irq_edge.sv
module gpio_edge_irq_edge import gpio_edge_irq_pkg::*; #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   lvl_i,
  input  logic [2*W-1:0] sense_i,
  output logic [W-1:0]   hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  for (genvar p = 0; p < W; p++) begin : g_pin
    sense_e code;
    logic   rise, fall, rise_en, fall_en;
    assign code    = sense_e'(sense_i[2*p +: 2]);
    assign rise    = lvl_i[p] & ~prev_q[p];
    assign fall    = ~lvl_i[p] & prev_q[p];
    assign rise_en = (code == SENSE_RISE) || (code == SENSE_BOTH);
    assign fall_en = (code == SENSE_FALL) || (code == SENSE_BOTH);
    assign hit_o[p] = (rise & rise_en) | (fall & fall_en);
  end
endmodule

// File: rtl/gpio_edge_irq_regs.sv
module gpio_edge_irq_regs import gpio_edge_irq_pkg::*; #(
  parameter int W      = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [W-1:0]      src_i,
  output logic [W-1:0]      mask_o,
  output logic [2*W-1:0]    sense_o,
  output logic [W-1:0]      src_clr_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int NB         = bytes_for(W);
  localparam int SB         = bytes_for(2 * W);
  localparam int MASK_BASE  = 0;
  localparam int SRC_BASE   = MASK_BASE + NB;
  localparam int SENSE_BASE = SRC_BASE + NB;
  localparam int CTRL_ADDR  = SENSE_BASE + SB;

  logic [W-1:0]      mask_q;
  logic [2*W-1:0]    sense_q;
  logic              hold_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] rd_val;

  // byte k of a region holds the most significant remaining slice
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr_i == ADDR_W'(MASK_BASE + k)) rd_val = mask_q[(NB-1-k)*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(SRC_BASE + k))  rd_val = src_i[(NB-1-k)*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < SB; k++)
      if (addr_i == ADDR_W'(SENSE_BASE + k)) rd_val = sense_q[(SB-1-k)*BYTE_W +: BYTE_W];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rd_val = {{(BYTE_W-1){1'b0}}, hold_q};
  end

  always_comb begin
    src_clr_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr_i == ADDR_W'(SRC_BASE + k)) begin
        if (wr_i)                 src_clr_o[(NB-1-k)*BYTE_W +: BYTE_W] = wdata_i;
        else if (rd_i && !hold_q) src_clr_o[(NB-1-k)*BYTE_W +: BYTE_W] = '1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      sense_q <= '0;
      hold_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_i) begin
        for (int k = 0; k < NB; k++)
          if (addr_i == ADDR_W'(MASK_BASE + k)) mask_q[(NB-1-k)*BYTE_W +: BYTE_W] <= wdata_i;
        for (int k = 0; k < SB; k++)
          if (addr_i == ADDR_W'(SENSE_BASE + k)) sense_q[(SB-1-k)*BYTE_W +: BYTE_W] <= wdata_i;
        if (addr_i == ADDR_W'(CTRL_ADDR)) hold_q <= wdata_i[0];
      end
      if (rd_i) rdata_q <= rd_val;
    end
  end

  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_edge_irq_src.sv
module gpio_edge_irq_src #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] src_o,
  output logic         irq_no
);
  logic [W-1:0] src_q;

  // a fresh edge beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) src_q <= '0;
    else         src_q <= (src_q & ~clr_i) | hit_i;

  assign src_o  = src_q;
  assign irq_no = ~|(src_q & ~mask_i);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq import gpio_edge_irq_pkg::*; #(
  parameter  int NUM_PINS    = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int MAP_SIZE    = 2 * bytes_for(NUM_PINS) + bytes_for(2 * NUM_PINS) + 1,
  localparam int ADDR_W      = $clog2(MAP_SIZE)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [BYTE_W-1:0]   reg_wdata_i,
  output logic [BYTE_W-1:0]   reg_rdata_o,
  output logic                irq_no
);
  logic [NUM_PINS-1:0]   lvl_sync;
  logic [NUM_PINS-1:0]   edge_hit;
  logic [NUM_PINS-1:0]   src_q;
  logic [NUM_PINS-1:0]   mask_q;
  logic [NUM_PINS-1:0]   src_clr;
  logic [2*NUM_PINS-1:0] sense_q;

  gpio_edge_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (lvl_sync)
  );

  gpio_edge_irq_edge #(.W(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_sync),
    .sense_i(sense_q),
    .hit_o  (edge_hit)
  );

  gpio_edge_irq_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .src_i    (src_q),
    .mask_o   (mask_q),
    .sense_o  (sense_q),
    .src_clr_o(src_clr),
    .rdata_o  (reg_rdata_o)
  );

  gpio_edge_irq_src #(.W(NUM_PINS)) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (edge_hit),
    .clr_i (src_clr),
    .mask_i(mask_q),
    .src_o (src_q),
    .irq_no(irq_no)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_no,
  input logic                  reg_wr_i,
  input logic                  reg_rd_i,
  input logic [7:0]            reg_rdata_o,
  input logic [NUM_PINS-1:0]   src_i,
  input logic [NUM_PINS-1:0]   hit_i,
  input logic [2*NUM_PINS-1:0] sense_i
);
  logic [NUM_PINS-1:0] sense_on;

  always_comb
    for (int p = 0; p < NUM_PINS; p++) sense_on[p] = |sense_i[2*p +: 2];

  assert_hit_needs_sense_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i & ~sense_on) == '0);

  assert_src_set_by_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & ~$past(src_i)) & ~$past(hit_i)) == '0);

  assert_edge_beats_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_i) & ~src_i) == '0);

  assert_clear_needs_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(src_i) & ~src_i) != '0) |-> $past(reg_wr_i || reg_rd_i));

  assert_irq_release_by_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(reg_wr_i || reg_rd_i));

  assert_irq_assert_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($past(|hit_i) || $past(reg_wr_i)));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_rd_i) |-> $stable(reg_rdata_o));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_no     (irq_no),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_rdata_o(reg_rdata_o),
  .src_i      (src_q),
  .hit_i      (edge_hit),
  .sense_i    (sense_q)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gpio = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  // reference model: [0] newest sample, [1] synchronized level, [2] previous level
  logic [15:0] m_hist[$];
  logic [15:0] m_mask, m_src;
  logic [31:0] m_sense;
  logic        m_hold;
  logic [7:0]  m_rdata;

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: return m_mask[15:8];
      1: return m_mask[7:0];
      2: return m_src[15:8];
      3: return m_src[7:0];
      4, 5, 6, 7: return m_sense[31-8*(a-4) -: 8];
      8: return {7'b0, m_hold};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{16'h0, 16'h0, 16'h0};
      m_mask = 16'hFFFF; m_src = '0; m_sense = '0; m_hold = 1'b0; m_rdata = '0;
    end else begin
      logic [15:0] hit, clr;
      hit = '0; clr = '0;
      for (int p = 0; p < 16; p++) begin
        bit up, dn;
        up = m_hist[1][p] && !m_hist[2][p];
        dn = !m_hist[1][p] && m_hist[2][p];
        if ((up && m_sense[2*p]) || (dn && m_sense[2*p+1])) hit[p] = 1'b1;
      end
      if (wr && addr == 2) clr[15:8] = wdata;
      if (wr && addr == 3) clr[7:0]  = wdata;
      if (!wr && rd && !m_hold && addr == 2) clr[15:8] = 8'hFF;
      if (!wr && rd && !m_hold && addr == 3) clr[7:0]  = 8'hFF;
      if (rd) m_rdata = m_read(int'(addr));
      if (wr) begin
        if (addr == 0) m_mask[15:8] = wdata;
        if (addr == 1) m_mask[7:0]  = wdata;
        if (addr >= 4 && addr <= 7) m_sense[31-8*(int'(addr)-4) -: 8] = wdata;
        if (addr == 8) m_hold = wdata[0];
      end
      m_src = (m_src & ~clr) | hit;
      m_hist.push_front(gpio);
      void'(m_hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 model irq", {7'b0, irq_n}, {7'b0, ~|(m_src & ~m_mask)});
      chk("R10 model rdata", rdata, m_rdata);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    chk(tag, {7'b0, irq_n}, {7'b0, exp});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    irq_chk(1'b1, "R1 irq idle");
    rd_chk(4'd0, 8'hFF, "R1 mask hi");
    rd_chk(4'd1, 8'hFF, "R1 mask lo");
    rd_chk(4'd2, 8'h00, "R1 source");
    rd_chk(4'd5, 8'h00, "R1 sense");
    rd_chk(4'd8, 8'h00, "R1 ctrl");

    // pin0 rise, pin5 fall, pin13 both, pin9 off
    wr_reg(4'd7, 8'h01);
    wr_reg(4'd6, 8'h08);
    wr_reg(4'd4, 8'h0C);
    rd_chk(4'd4, 8'h0C, "R4 pins15-12");
    rd_chk(4'd6, 8'h08, "R4 pins7-4");
    rd_chk(4'd5, 8'h00, "R4 pins11-8");

    wr_reg(4'd8, 8'h01);
    wr_reg(4'd1, 8'hFE);
    irq_chk(1'b1, "R5 nothing pending");

    gpio[0] = 1'b1;
    step(2);
    irq_chk(1'b1, "R2 latency");
    step(1);
    irq_chk(1'b0, "R2 rise sets");
    rd_chk(4'd3, 8'h01, "R2 source");
    rd_chk(4'd3, 8'h01, "R8 hold keeps");
    irq_chk(1'b0, "R8 hold irq");

    wr_reg(4'd3, 8'h00);
    rd_chk(4'd3, 8'h01, "R6 zero keeps");
    wr_reg(4'd3, 8'h01);
    irq_chk(1'b1, "R7 release");
    rd_chk(4'd3, 8'h00, "R6 one clears");

    gpio[0] = 1'b0;
    step(4);
    rd_chk(4'd3, 8'h00, "R3 rise-only ignores fall");
    gpio[5] = 1'b1;
    step(4);
    rd_chk(4'd3, 8'h00, "R3 fall-only ignores rise");
    gpio[5] = 1'b0;
    step(4);
    rd_chk(4'd3, 8'h20, "R3 fall");
    irq_chk(1'b1, "R5 masked latches");
    wr_reg(4'd1, 8'hDE);
    irq_chk(1'b0, "R5 unmask");

    gpio[13] = 1'b1;
    step(4);
    rd_chk(4'd2, 8'h20, "R3 both rise");
    wr_reg(4'd2, 8'h20);
    rd_chk(4'd2, 8'h00, "R6 hi clear");
    gpio[13] = 1'b0;
    step(4);
    rd_chk(4'd2, 8'h20, "R3 both fall");
    wr_reg(4'd2, 8'h20);

    gpio[9] = 1'b1;
    step(4);
    gpio[9] = 1'b0;
    step(4);
    rd_chk(4'd2, 8'h00, "R3 off");

    wr_reg(4'd8, 8'h00);
    rd_chk(4'd3, 8'h20, "R8 read value");
    rd_chk(4'd3, 8'h00, "R8 read cleared");
    irq_chk(1'b1, "R7 all clear");

    // edge sampled on the same clock edge as a clear
    gpio[13] = 1'b1;
    step(4);
    gpio[13] = 1'b0;
    step(2);
    wr_reg(4'd2, 8'h20);
    rd_chk(4'd2, 8'h20, "R9 edge wins");
    rd_chk(4'd2, 8'h00, "R8 read clears hi");

    wr_reg(4'd15, 8'hFF);
    rd_chk(4'd15, 8'h00, "R10 unmapped read");
    rd_chk(4'd1, 8'hDE, "R10 mask untouched");
    rd_chk(4'd9, 8'h00, "R10 unmapped 9");

    wr_reg(4'd0, 8'hDF);
    rd_chk(4'd0, 8'hDF, "R11 mask hi byte");
    rd_chk(4'd1, 8'hDE, "R11 mask lo byte");
    gpio[13] = 1'b1;
    step(4);
    irq_chk(1'b0, "R11 pin13 via hi byte");
    rd_chk(4'd2, 8'h20, "R11 source hi byte");
    irq_chk(1'b1, "R7 cleared by read");

    step(2);
    finish_run();
  end
endmodule